// File: doc/BRIEF.md
# Four-Channel PCM Time-Slot Serial Port

This block is the digital half of the time-division multiplexed serial interface of a four-channel voice codec. Each channel presents one 8-bit companded sample. When that channel's own frame-sync pulse arrives, the block shifts the sample out on a transmit data line that all four channels share. In the same slot it collects an 8-bit sample from a shared receive data line and stores it in that channel's receive register.

A static mode input sets where the slot starts. In immediate framing the first bit leaves at the same bit-clock edge that first sees the frame sync high. In lagged framing the first bit leaves one bit clock later. Every interval is counted in bit-clock periods only, so the port behaves the same at either supported line rate. Each channel can be powered down on its own. A powered-down channel keeps its slot timing but does not drive the line and does not update its receive register. A companding-law select input travels with each received word as a flag. Overlapping frame syncs are resolved in favour of the lowest channel number and reported on a one-cycle flag.

Top module: `pcm_tdm_port`

## Requirements
- R1: While reset is high and at the first edge after it falls, tx_oe, tx_data, rx_valid and collide are 0 and rx_words is all zero.
- R2: With lag_mode=0, a channel n whose fsync[n] is sampled high at a rising edge (low at the previous edge) drives tx_words[8n+7:8n] on tx_data, MSB first. The first bit comes from that same edge, then one bit per edge for 8 consecutive edges, with tx_oe high for those 8 periods.
- R3: With lag_mode=1, tx_oe stays low for the period after the edge that samples the frame sync, and the 8 bits of R2 start one edge later.
- R4: Outside the 8 bit periods of an active slot, tx_oe and tx_data are 0.
- R5: While pdn[n]=1, the slot of channel n keeps its timing but tx_oe stays 0, rx_valid[n] does not pulse and rx_words[8n+7:8n] keeps its previous value.
- R6: rx_data is sampled on the falling edge inside each of the 8 bit periods, MSB first. At the rising edge after the last bit, rx_words[8n+7:8n] takes the word and rx_valid[n] is high for exactly one cycle.
- R7: At that same commit edge, rx_law[n] takes the value of law_sel (0 = mu-law, 1 = A-law).
- R8: If several fsync bits rise at the same edge while the port is idle, only the lowest-numbered channel gets the slot, and collide is high for the one cycle after that edge.
- R9: A frame-sync rise that arrives while a slot is in progress is ignored. The running slot continues unchanged, no slot follows for the intruding channel, and collide is high for one cycle after that edge.
- R10: A new slot may begin at the edge right after the previous slot's last bit. That edge also commits the previous slot's receive word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; transmit changes on the rising edge, receive sampled on the falling edge |
| rst | input | 1 | Synchronous active-high reset |
| lag_mode | input | 1 | Static framing select: 0 immediate, 1 first bit one clock after frame sync |
| law_sel | input | 1 | Companding law flag: 0 mu-law, 1 A-law |
| fsync | input | 4 | Per-channel frame sync, bit n for channel n |
| pdn | input | 4 | Per-channel power-down, bit n for channel n |
| tx_words | input | 32 | Transmit samples, channel n in bits 8n+7:8n |
| tx_data | output | 1 | Shared serial transmit data |
| tx_oe | output | 1 | Transmit output enable; low means high-impedance |
| rx_data | input | 1 | Shared serial receive data |
| rx_words | output | 32 | Received samples, channel n in bits 8n+7:8n |
| rx_law | output | 4 | Law flag stored with each channel's received word |
| rx_valid | output | 4 | One-cycle pulse when channel n's received word is committed |
| collide | output | 1 | One-cycle flag for an ignored or losing frame-sync rise |

## Verification
The bench targets the boundary between framings. A design that starts lagged slots one edge early, or immediate slots one edge late, shows the wrong bit at every sampling point. Simultaneous rises check that the lowest channel wins, and a rise in the middle of a slot checks that it is ignored. A wrong arbiter sends another channel's word or breaks off the running slot. Back-to-back slots with no idle bit between them catch a port that needs a gap or loses the first slot's commit. Powered-down slots catch a port that drives the line or overwrites the stored word.

// File: rtl/pcm_ts_pkg.sv
package pcm_ts_pkg;

    localparam int NCH   = 4;
    localparam int WBITS = 8;
    localparam int CHW   = $clog2(NCH);
    localparam int CNTW  = $clog2(WBITS + 1);
    localparam int IDXW  = $clog2(NCH * WBITS);

    typedef logic [CHW-1:0]  chan_t;
    typedef logic [CNTW-1:0] cnt_t;

    typedef struct packed {
        logic  busy;   // a slot owns the line
        logic  lag;    // one idle period still to spend before bit 7
        chan_t ch;     // owner channel
        cnt_t  rem;    // bits still to drive
    } slot_t;

    // index of the lowest set bit, 0 when none is set
    function automatic chan_t lowest_set(input logic [NCH-1:0] v);
        chan_t r;
        r = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (v[i]) r = chan_t'(i);
        end
        return r;
    endfunction

    function automatic logic multi_set(input logic [NCH-1:0] v);
        return (v & (v - 1'b1)) != '0;
    endfunction

endpackage

// File: rtl/pcm_fs_arbiter.sv
module pcm_fs_arbiter
    import pcm_ts_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] fsync,
    input  logic           busy,
    output logic           start,
    output chan_t          win,
    output logic           collide
);

    logic [NCH-1:0] fs_q;
    logic [NCH-1:0] rise;

    always_comb begin
        rise  = fsync & ~fs_q;
        start = (|rise) & ~busy;
        win   = lowest_set(rise);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fs_q    <= '0;
            collide <= 1'b0;
        end else begin
            fs_q    <= fsync;
            collide <= (|rise) & (busy | multi_set(rise));
        end
    end

    // R8
    win_is_rising_chk: assert property (@(posedge clk) disable iff (rst)
        start |-> rise[win]);

    // R8
    win_is_lowest_chk: assert property (@(posedge clk) disable iff (rst)
        start |-> ((rise & ((NCH'(1) << win) - NCH'(1))) == '0));

    // R9
    busy_rise_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && (|rise)) |=> collide);

endmodule

// File: rtl/pcm_tx_sequencer.sv
module pcm_tx_sequencer
    import pcm_ts_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 lag_mode,
    input  logic [NCH-1:0]       pdn,
    input  logic [NCH*WBITS-1:0] tx_words,
    input  logic                 start,
    input  chan_t                win,
    output logic                 busy,
    output logic                 tx_data,
    output logic                 tx_oe,
    output logic                 cap_en,
    output logic                 cap_last,
    output chan_t                cap_ch
);

    slot_t st_q, cur, nxt;
    logic  drive;
    logic  live;
    logic [IDXW-1:0] idx;

    always_comb begin
        cur = st_q;
        if (start) begin
            cur.busy = 1'b1;
            cur.lag  = lag_mode;
            cur.ch   = win;
            cur.rem  = cnt_t'(WBITS);
        end
        nxt   = cur;
        drive = 1'b0;
        if (cur.busy) begin
            if (cur.lag) begin
                nxt.lag = 1'b0;
            end else begin
                drive    = 1'b1;
                nxt.rem  = cur.rem - 1'b1;
                nxt.busy = (cur.rem != cnt_t'(1));
            end
        end
        live = drive & ~pdn[cur.ch];
        idx  = IDXW'(cur.ch) * IDXW'(WBITS) + IDXW'(cur.rem) - IDXW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= '0;
            tx_oe    <= 1'b0;
            tx_data  <= 1'b0;
            cap_en   <= 1'b0;
            cap_last <= 1'b0;
            cap_ch   <= '0;
        end else begin
            st_q     <= nxt;
            tx_oe    <= live;
            tx_data  <= live & tx_words[idx];
            cap_en   <= live;
            cap_last <= live & (cur.rem == cnt_t'(1));
            cap_ch   <= cur.ch;
        end
    end

    assign busy = st_q.busy;

    // R4
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!st_q.busy && !start) |=> !tx_oe);

    // R3
    lag_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (start && lag_mode) |=> !tx_oe);

    // R2
    slot_count_chk: assert property (@(posedge clk) disable iff (rst)
        st_q.busy |-> (st_q.rem != '0));

    // R6
    last_inside_slot_chk: assert property (@(posedge clk) disable iff (rst)
        cap_last |-> (cap_en && tx_oe));

endmodule

// File: rtl/pcm_rx_capture.sv
module pcm_rx_capture
    import pcm_ts_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 rx_data,
    input  logic                 cap_en,
    input  logic                 cap_last,
    input  chan_t                cap_ch,
    input  logic                 law_sel,
    output logic [NCH*WBITS-1:0] rx_words,
    output logic [NCH-1:0]       rx_law,
    output logic [NCH-1:0]       rx_valid
);

    logic [WBITS-1:0] sr;

    // falling-edge sampling of the shared receive line
    always_ff @(negedge clk) begin
        if (rst) sr <= '0;
        else if (cap_en) sr <= {sr[WBITS-2:0], rx_data};
    end

    for (genvar n = 0; n < NCH; n++) begin : g_chan
        logic [WBITS-1:0] word_q;
        logic             law_q;
        logic             vld_q;
        logic             hit;

        assign hit = cap_last && (cap_ch == chan_t'(n));

        always_ff @(posedge clk) begin
            if (rst) begin
                word_q <= '0;
                law_q  <= 1'b0;
                vld_q  <= 1'b0;
            end else begin
                vld_q <= hit;
                if (hit) begin
                    word_q <= sr;
                    law_q  <= law_sel;
                end
            end
        end

        assign rx_words[n*WBITS +: WBITS] = word_q;
        assign rx_law[n]                  = law_q;
        assign rx_valid[n]                = vld_q;
    end

    // R6
    valid_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(rx_valid));

    // R6
    valid_single_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_valid != '0) |=> (rx_valid == '0));

endmodule

// File: rtl/pcm_tdm_port.sv
module pcm_tdm_port
    import pcm_ts_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 lag_mode,
    input  logic                 law_sel,
    input  logic [NCH-1:0]       fsync,
    input  logic [NCH-1:0]       pdn,
    input  logic [NCH*WBITS-1:0] tx_words,
    output logic                 tx_data,
    output logic                 tx_oe,
    input  logic                 rx_data,
    output logic [NCH*WBITS-1:0] rx_words,
    output logic [NCH-1:0]       rx_law,
    output logic [NCH-1:0]       rx_valid,
    output logic                 collide
);

    logic  busy, start, cap_en, cap_last;
    chan_t win, cap_ch;

    pcm_fs_arbiter u_arb (
        .clk     (clk),
        .rst     (rst),
        .fsync   (fsync),
        .busy    (busy),
        .start   (start),
        .win     (win),
        .collide (collide)
    );

    pcm_tx_sequencer u_tx (
        .clk      (clk),
        .rst      (rst),
        .lag_mode (lag_mode),
        .pdn      (pdn),
        .tx_words (tx_words),
        .start    (start),
        .win      (win),
        .busy     (busy),
        .tx_data  (tx_data),
        .tx_oe    (tx_oe),
        .cap_en   (cap_en),
        .cap_last (cap_last),
        .cap_ch   (cap_ch)
    );

    pcm_rx_capture u_rx (
        .clk      (clk),
        .rst      (rst),
        .rx_data  (rx_data),
        .cap_en   (cap_en),
        .cap_last (cap_last),
        .cap_ch   (cap_ch),
        .law_sel  (law_sel),
        .rx_words (rx_words),
        .rx_law   (rx_law),
        .rx_valid (rx_valid)
    );

    // R5
    quiet_when_down_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_oe && $stable(pdn)) |-> (pdn != '1));

endmodule

// File: tb/pcm_tdm_port_test.sv
`timescale 1ns/1ps
module pcm_tdm_port_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        lag_mode, law_sel, rx_data;
    logic [3:0]  fsync, pdn;
    logic [31:0] tx_words;
    logic        tx_data, tx_oe, collide;
    logic [31:0] rx_words;
    logic [3:0]  rx_law, rx_valid;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;
    logic [7:0] exp_rx [4];

    always #2 clk = ~clk;

    pcm_tdm_port uut (
        .clk(clk), .rst(rst), .lag_mode(lag_mode), .law_sel(law_sel),
        .fsync(fsync), .pdn(pdn), .tx_words(tx_words), .tx_data(tx_data),
        .tx_oe(tx_oe), .rx_data(rx_data), .rx_words(rx_words),
        .rx_law(rx_law), .rx_valid(rx_valid), .collide(collide)
    );

    // {ch[20:19], lag[18], pd[17], law[16], tx[15:8], rx[7:0]}
    localparam logic [20:0] VEC [6] = '{
        {2'd0, 1'b0, 1'b0, 1'b0, 8'hA5, 8'h3C},
        {2'd1, 1'b1, 1'b0, 1'b1, 8'h81, 8'hC3},
        {2'd2, 1'b0, 1'b0, 1'b1, 8'h7E, 8'h01},
        {2'd3, 1'b1, 1'b0, 1'b0, 8'hFF, 8'h80},
        {2'd2, 1'b1, 1'b1, 1'b0, 8'h55, 8'hAA},
        {2'd1, 1'b0, 1'b1, 1'b1, 8'h0F, 8'hF0}
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic drive_slot(input logic [3:0] fsmask, input int ch, input bit lag, input bit pd,
                              input logic [7:0] txw, input logic [7:0] rxw,
                              input logic [3:0] prev_commit, input logic [3:0] late_fs);
        lag_mode = lag;
        pdn      = pd ? (4'b1 << ch) : 4'b0;
        tx_words[ch*8 +: 8] = txw;
        fsync    = fsmask;
        tick();
        chk(rx_valid == prev_commit, "R10 commit at next slot start", rx_valid, prev_commit);
        chk(collide == ((fsmask & (fsmask - 1)) != 0), "R8 collide on start", collide,
            ((fsmask & (fsmask - 1)) != 0));
        fsync = 4'b0;
        if (lag) begin
            chk(tx_oe == 1'b0, "R3 lag period quiet", tx_oe, 0);
            tick();
        end
        for (int b = 7; b >= 0; b--) begin
            if (b != 7) tick();
            chk(tx_oe == !pd, pd ? "R5 oe low when down" : "R2 oe in slot", tx_oe, !pd);
            if (!pd) chk(tx_data == txw[b], lag ? "R3 lagged bit" : "R2 bit", tx_data, txw[b]);
            rx_data = rxw[b];
            if (b == 6) fsync = late_fs;
            if (b == 5) begin
                if (late_fs != 0) chk(collide == 1'b1, "R9 busy rise flagged", collide, 1);
                fsync = 4'b0;
            end
        end
    endtask

    task automatic finish_slot(input int ch, input bit pd, input logic [7:0] rxw, input bit law);
        logic [3:0] ev;
        tick();
        ev = pd ? 4'b0 : (4'b1 << ch);
        chk(tx_oe == 1'b0 && tx_data == 1'b0, "R4 quiet after slot", {tx_oe, tx_data}, 0);
        chk(rx_valid == ev, pd ? "R5 no commit when down" : "R6 commit pulse", rx_valid, ev);
        if (!pd) exp_rx[ch] = rxw;
        chk(rx_words[ch*8 +: 8] == exp_rx[ch], pd ? "R5 word kept" : "R6 word", rx_words[ch*8 +: 8], exp_rx[ch]);
        if (!pd) chk(rx_law[ch] == law, "R7 law flag", rx_law[ch], law);
        tick();
        chk(rx_valid == 4'b0, "R6 single pulse", rx_valid, 0);
        chk(tx_oe == 1'b0, "R4 idle", tx_oe, 0);
    endtask

    initial begin
        #800000;
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) exp_rx[i] = 8'h00;
        rst = 1'b1; lag_mode = 1'b0; law_sel = 1'b0; rx_data = 1'b0;
        fsync = 4'b0; pdn = 4'b0; tx_words = 32'hC6D1_93B4;
        repeat (3) tick();
        chk(tx_oe == 0 && tx_data == 0, "R1 tx quiet in reset", {tx_oe, tx_data}, 0);
        chk(rx_valid == 0 && collide == 0, "R1 flags clear", {rx_valid, collide}, 0);
        chk(rx_words == 0, "R1 words clear", rx_words, 0);
        rst = 1'b0;
        tick();
        chk(tx_oe == 0 && rx_valid == 0, "R1 after release", {tx_oe, rx_valid}, 0);

        // table of slots
        for (int v = 0; v < 6; v++) begin
            int ch;
            ch = int'(VEC[v][20:19]);
            law_sel = VEC[v][16];
            drive_slot(4'b1 << ch, ch, VEC[v][18], VEC[v][17], VEC[v][15:8], VEC[v][7:0], 4'b0, 4'b0);
            finish_slot(ch, VEC[v][17], VEC[v][7:0], VEC[v][16]);
        end
        pdn = 4'b0;

        // R8 simultaneous rises: channel 1 beats 2
        law_sel = 1'b1;
        tx_words[23:16] = 8'hE7;
        drive_slot(4'b0110, 1, 1'b0, 1'b0, 8'h96, 8'h5A, 4'b0, 4'b0);
        finish_slot(1, 1'b0, 8'h5A, 1'b1);

        // R9 rise during a running slot is ignored
        law_sel = 1'b0;
        drive_slot(4'b0001, 0, 1'b0, 1'b0, 8'h6C, 8'h39, 4'b0, 4'b0100);
        finish_slot(0, 1'b0, 8'h39, 1'b0);
        for (int k = 0; k < 3; k++) begin
            tick();
            chk(tx_oe == 0 && rx_valid == 0, "R9 intruder gets no slot", {tx_oe, rx_valid}, 0);
        end

        // R10 back-to-back slots, second one lagged
        drive_slot(4'b0001, 0, 1'b0, 1'b0, 8'hB2, 8'h4D, 4'b0, 4'b0);
        exp_rx[0] = 8'h4D;
        drive_slot(4'b1000, 3, 1'b1, 1'b0, 8'h1E, 8'hE1, 4'b0001, 4'b0);
        finish_slot(3, 1'b0, 8'hE1, 1'b0);
        chk(rx_words[7:0] == exp_rx[0], "R10 first word kept", rx_words[7:0], exp_rx[0]);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule